// File: doc/BRIEF.md
# Interrupt Register Bank with Fast-Interrupt Routing

This block is the software-visible register bank of an interrupt controller with 51 sources. A separate trigger detector drives the pending vector into it, together with that detector's per-source configuration (level or edge mode, both-edge mode, active polarity). The bank stores the per-source enable mask and the fast-interrupt select mask. It folds these with the pending vector into two outputs: a normal interrupt and a fast interrupt. Each source reaches exactly one of the two outputs, as chosen by its select bit.

Software reaches the bank through a simple synchronous 32-bit read/write port. Every conceptual 64-bit vector takes two word addresses: address bit 2 chooses the upper word, which holds sources 32 to 50. The enable mask has one address that sets bits and another that clears them, so no read-modify-write is needed. Writing to the edge-clear address produces a one-cycle clear pulse toward the detector for the edge-mode sources named in the data.

Top module: `intc_regbank`

## Requirements
- R1: After reset, irq_o and fiq_o are low. The enable, select and software-trigger words all read zero.
- R2: An access is ignored when it is below byte offset 0x80 or when addr[1:0] is non-zero. Such a read returns zero and such a write changes nothing.
- R3: Offsets are relative to 0x80 and addr[2] selects the upper word. The upper word holds sources 32..50 in bits 18..0. Written bits 31..19 of the upper word are dropped, and those bits read as zero.
- R4: A write to relative 0x20 ORs the written ones into the enable mask. Reading 0x20 returns the mask.
- R5: A write to relative 0x28 clears each enable bit written as one and leaves the others unchanged.
- R6: A write to relative 0x18 replaces the addressed word of the select mask, and the other word keeps its value. Reading 0x18 returns the mask.
- R7: Status reads: 0x00 returns pending AND enable AND NOT select; 0x08 returns pending AND enable AND select; 0x10 returns pending; 0x60 returns pending AND NOT level-mode.
- R8: Reads of 0x40, 0x48 and 0x50 return the level-mode, both-edge and polarity inputs. Writes to these offsets have no effect.
- R9: Reads of the write-only offsets 0x28, 0x38 and 0x58 return zero. So do reads of any relative offset above 0x64.
- R10: Writes to the status offsets 0x00, 0x08, 0x10 and 0x60 have no effect on the enable or select masks or on the outputs.
- R11: Writes to relative 0x30 and 0x38 have no effect. Reads of 0x30 return a software-trigger word that stays zero.
- R12: fiq_o is high when any source is pending, enabled and selected. irq_o is high when any source is pending, enabled and not selected. Both outputs are registered and follow a change of their inputs at the next clock edge.
- R13: During a write to relative 0x58, edge_clr is the addressed word's data placed at that word's source positions, ANDed with NOT level-mode. At all other times edge_clr is zero.
- R14: rdata is loaded on the clock edge that samples rd_en and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| raw_pend | input | 51 | Pending vector from the trigger detector |
| lvl_mode | input | 51 | Per-source level mode (1) or edge mode (0) |
| both_edge | input | 51 | Per-source both-edge mode |
| pol_high | input | 51 | Per-source active-high/rising polarity |
| edge_clr | output | 51 | Clear pulse for edge-mode pending bits |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets word splitting. It writes all ones to the upper enable word, where a design that failed to mask would report bits 31..19 as set. It rewrites one select word and reads back the other, which catches a design that clears the whole vector. It routes single sources in each word to both outputs, so swapping the select polarity or dropping the upper word moves or loses an interrupt. It also probes reads below the window and unaligned reads, write-only and unmapped reads, and writes to status and configuration offsets, all of which a sloppy decoder would alias onto live registers. Finally, it checks that the edge-clear pulse spares level-mode sources.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [3:0] {
        RS_IRQ_ST,
        RS_FIQ_ST,
        RS_PEND,
        RS_SELECT,
        RS_EN_SET,
        RS_EN_CLR,
        RS_SW_SET,
        RS_SW_CLR,
        RS_LVL,
        RS_BOTH,
        RS_POL,
        RS_EDGE_CLR,
        RS_EDGE_ST,
        RS_NONE
    } reg_sel_e;
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
    import intc_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] WIN_BASE = 12'h080
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      rsel,
    output logic          hi
);
    localparam int IW = AW - 3;

    logic [AW-3:0] rel_w;
    logic [IW-1:0] idx;
    logic          ok;

    always_comb begin
        ok    = (addr >= WIN_BASE) && (addr[1:0] == 2'b00);
        rel_w = addr[AW-1:2] - WIN_BASE[AW-1:2];
        hi    = rel_w[0];
        idx   = rel_w[AW-3:1];
        rsel  = RS_NONE;
        if (ok) begin
            case (idx)
                IW'(0):  rsel = RS_IRQ_ST;
                IW'(1):  rsel = RS_FIQ_ST;
                IW'(2):  rsel = RS_PEND;
                IW'(3):  rsel = RS_SELECT;
                IW'(4):  rsel = RS_EN_SET;
                IW'(5):  rsel = RS_EN_CLR;
                IW'(6):  rsel = RS_SW_SET;
                IW'(7):  rsel = RS_SW_CLR;
                IW'(8):  rsel = RS_LVL;
                IW'(9):  rsel = RS_BOTH;
                IW'(10): rsel = RS_POL;
                IW'(11): rsel = RS_EDGE_CLR;
                IW'(12): rsel = RS_EDGE_ST;
                default: rsel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/intc_view_mux.sv
module intc_view_mux
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 51,
    parameter int DW      = 32
) (
    input  reg_sel_e             rsel,
    input  logic                 hi,
    input  logic [NUM_SRC-1:0]   pend,
    input  logic [NUM_SRC-1:0]   en,
    input  logic [NUM_SRC-1:0]   fsel,
    input  logic [NUM_SRC-1:0]   sw,
    input  logic [NUM_SRC-1:0]   lvl,
    input  logic [NUM_SRC-1:0]   both,
    input  logic [NUM_SRC-1:0]   pol,
    output logic [DW-1:0]        word
);
    localparam int PAD = 2*DW - NUM_SRC;

    logic [NUM_SRC-1:0] view;
    logic [2*DW-1:0]    wide;

    always_comb begin
        case (rsel)
            RS_IRQ_ST:  view = pend & en & ~fsel;
            RS_FIQ_ST:  view = pend & en & fsel;
            RS_PEND:    view = pend;
            RS_SELECT:  view = fsel;
            RS_EN_SET:  view = en;
            RS_SW_SET:  view = sw;
            RS_LVL:     view = lvl;
            RS_BOTH:    view = both;
            RS_POL:     view = pol;
            RS_EDGE_ST: view = pend & ~lvl;
            default:    view = '0;
        endcase
        wide = {{PAD{1'b0}}, view};
        word = hi ? wide[2*DW-1:DW] : wide[DW-1:0];
    end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
    parameter int NUM_SRC = 51
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] fsel,
    output logic               irq_o,
    output logic               fiq_o
);
    typedef struct packed {
        logic irq;
        logic fiq;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.irq = |(pend & en & ~fsel);
        out_d.fiq = |(pend & en & fsel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o = out_q.irq;
    assign fiq_o = out_q.fiq;

    // R12
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> (!irq_o && !fiq_o));

    // R12
    no_pend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_o && !fiq_o));

    // R12
    all_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == '1) |=> !irq_o);
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 51,
    parameter int DW      = 32,
    parameter int AW      = 12,
    parameter logic [AW-1:0] WIN_BASE = 12'h080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NUM_SRC-1:0] raw_pend,
    input  logic [NUM_SRC-1:0] lvl_mode,
    input  logic [NUM_SRC-1:0] both_edge,
    input  logic [NUM_SRC-1:0] pol_high,
    output logic [NUM_SRC-1:0] edge_clr,
    output logic               irq_o,
    output logic               fiq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] fsel;
        logic [NUM_SRC-1:0] sw;
        logic [DW-1:0]      rdata;
    } bank_t;

    bank_t    st_d, st_q;
    reg_sel_e rsel;
    logic     hi;
    logic [DW-1:0]      view_word;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] keep;

    function automatic logic [NUM_SRC-1:0] place(input logic [DW-1:0] w, input logic upper);
        logic [2*DW-1:0] wide;
        wide = upper ? {w, {DW{1'b0}}} : {{DW{1'b0}}, w};
        return wide[NUM_SRC-1:0];
    endfunction

    intc_addr_dec #(.AW(AW), .WIN_BASE(WIN_BASE)) u_dec (
        .addr (addr),
        .rsel (rsel),
        .hi   (hi)
    );

    intc_view_mux #(.NUM_SRC(NUM_SRC), .DW(DW)) u_mux (
        .rsel (rsel),
        .hi   (hi),
        .pend (raw_pend),
        .en   (st_q.en),
        .fsel (st_q.fsel),
        .sw   (st_q.sw),
        .lvl  (lvl_mode),
        .both (both_edge),
        .pol  (pol_high),
        .word (view_word)
    );

    intc_route #(.NUM_SRC(NUM_SRC)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (raw_pend),
        .en    (st_q.en),
        .fsel  (st_q.fsel),
        .irq_o (irq_o),
        .fiq_o (fiq_o)
    );

    always_comb begin
        wmask = place(wdata, hi);
        keep  = place({DW{1'b1}}, !hi);
        st_d  = st_q;
        if (wr_en) begin
            case (rsel)
                RS_EN_SET: st_d.en   = st_q.en | wmask;
                RS_EN_CLR: st_d.en   = st_q.en & ~wmask;
                RS_SELECT: st_d.fsel = (st_q.fsel & keep) | wmask;
                default:   st_d      = st_q;
            endcase
        end
        if (rd_en) st_d.rdata = view_word;
        edge_clr = (wr_en && rsel == RS_EDGE_CLR) ? (wmask & ~lvl_mode) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel == RS_EN_SET) |=> ((st_q.en & $past(wmask)) == $past(wmask)));

    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel == RS_EN_CLR) |=> ((st_q.en & $past(wmask)) == '0));

    // R6
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel == RS_SELECT) |=> ((st_q.fsel & $past(keep)) == ($past(st_q.fsel) & $past(keep))));

    // R2
    win_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < WIN_BASE) |=> (rdata == '0));

    // R14
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R13
    edge_clr_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_clr & lvl_mode) == '0) && (!wr_en -> edge_clr == '0));
endmodule

// File: tb/intc_regbank_bench.sv
module intc_regbank_bench;
    localparam int N = 51;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  raw_pend = '0;
    logic [N-1:0]  lvl_mode = 51'h1F07FFF8FFFF;
    logic [N-1:0]  both_edge = 51'hF800070000;
    logic [N-1:0]  pol_high = 51'h5F07FFF8FFFF;
    logic [N-1:0]  edge_clr;
    logic          irq_o, fiq_o;

    logic [N-1:0]  m_en = '0;
    logic [N-1:0]  m_sel = '0;
    int n_chk = 0;
    int n_fail = 0;

    intc_regbank u_intc_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .raw_pend(raw_pend), .lvl_mode(lvl_mode),
        .both_edge(both_edge), .pol_high(pol_high), .edge_clr(edge_clr),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] lo_w(input logic [N-1:0] v);
        return v[31:0];
    endfunction
    function automatic logic [31:0] hi_w(input logic [N-1:0] v);
        return {13'b0, v[N-1:32]};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, {32'b0, d}, {32'b0, exp});
    endtask

    task automatic chk_outs(input string req);
        chk(req, {62'b0, irq_o, fiq_o},
            {62'b0, |(raw_pend & m_en & ~m_sel), |(raw_pend & m_en & m_sel)});
    endtask

    task automatic t_reset;
        chk("R1 outs", {62'b0, irq_o, fiq_o}, 64'd0);
        rd_chk("R1 en lo", 12'h0A0, 32'h0);
        rd_chk("R1 en hi", 12'h0A4, 32'h0);
        rd_chk("R1 sel lo", 12'h098, 32'h0);
        rd_chk("R1 sel hi", 12'h09C, 32'h0);
        rd_chk("R1 sw", 12'h0B0, 32'h0);
    endtask

    task automatic t_window;
        raw_pend = 51'h1234_5678;
        lvl_mode = '0;
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk("R2 en untouched", 12'h0A0, 32'h0);
        rd_chk("R2 low read", 12'h010, 32'h0);
        rd_chk("R2 unaligned read", 12'h091, 32'h0);
        wr(12'h0A2, 32'hFFFF_FFFF);
        rd_chk("R2 unaligned write", 12'h0A0, 32'h0);
        lvl_mode = 51'h1F07FFF8FFFF;
    endtask

    task automatic t_enable;
        wr(12'h0A0, 32'h0000_00F0); m_en[31:0] |= 32'h0000_00F0;
        wr(12'h0A0, 32'h0000_000F); m_en[31:0] |= 32'h0000_000F;
        rd_chk("R4 or-set", 12'h0A0, 32'h0000_00FF);
        wr(12'h0A4, 32'hFFFF_FFFF); m_en[N-1:32] = '1;
        rd_chk("R3 hi mask", 12'h0A4, 32'h0007_FFFF);
        rd_chk("R3 lo intact", 12'h0A0, 32'h0000_00FF);
        wr(12'h0A8, 32'h0000_0033); m_en[31:0] &= ~32'h0000_0033;
        rd_chk("R5 clear", 12'h0A0, 32'h0000_00CC);
        wr(12'h0AC, 32'h0000_0001); m_en[32] = 1'b0;
        rd_chk("R5 clear hi", 12'h0A4, 32'h0007_FFFE);
    endtask

    task automatic t_select;
        wr(12'h098, 32'h1234_5678); m_sel[31:0] = 32'h1234_5678;
        wr(12'h09C, 32'hFFF5_5555); m_sel[N-1:32] = 19'h5_5555;
        rd_chk("R6 lo", 12'h098, 32'h1234_5678);
        rd_chk("R3 sel hi", 12'h09C, 32'h0005_5555);
        wr(12'h098, 32'hAAAA_0000); m_sel[31:0] = 32'hAAAA_0000;
        rd_chk("R6 hi kept", 12'h09C, 32'h0005_5555);
        rd_chk("R6 lo replaced", 12'h098, 32'hAAAA_0000);
    endtask

    task automatic t_route;
        wr(12'h0A0, 32'hFFFF_FFFF); m_en[31:0] = '1;
        wr(12'h0A4, 32'h0000_0001); m_en[32] = 1'b1;
        @(negedge clk);
        raw_pend = 51'h1;
        @(negedge clk);
        chk("R12 irq only", {62'b0, irq_o, fiq_o}, 64'd2);
        raw_pend = 51'h2_0000;
        @(negedge clk);
        chk("R12 fiq only", {62'b0, irq_o, fiq_o}, 64'd1);
        raw_pend = 51'h1_0000_0000 | 51'h2;
        @(negedge clk);
        chk_outs("R12 hi fiq lo irq");
        raw_pend = 51'h6_0000_0000_0000 | 51'h4_0001;
        @(negedge clk);
        chk_outs("R12 mixed");
        rd_chk("R7 irq st lo", 12'h080, lo_w(raw_pend & m_en & ~m_sel));
        rd_chk("R7 irq st hi", 12'h084, hi_w(raw_pend & m_en & ~m_sel));
        rd_chk("R7 fiq st lo", 12'h088, lo_w(raw_pend & m_en & m_sel));
        rd_chk("R7 fiq st hi", 12'h08C, hi_w(raw_pend & m_en & m_sel));
        rd_chk("R7 pend hi", 12'h094, hi_w(raw_pend));
        rd_chk("R7 edge st lo", 12'h0E0, lo_w(raw_pend & ~lvl_mode));
        rd_chk("R7 edge st hi", 12'h0E4, hi_w(raw_pend & ~lvl_mode));
        wr(12'h098, 32'h0000_0000); m_sel[31:0] = '0;
        @(negedge clk);
        chk_outs("R12 after select change");
    endtask

    task automatic t_views;
        wr(12'h0C0, 32'hFFFF_FFFF);
        wr(12'h0CC, 32'hFFFF_FFFF);
        rd_chk("R8 lvl lo", 12'h0C0, lo_w(lvl_mode));
        rd_chk("R8 lvl hi", 12'h0C4, hi_w(lvl_mode));
        rd_chk("R8 both lo", 12'h0C8, lo_w(both_edge));
        rd_chk("R8 both hi", 12'h0CC, hi_w(both_edge));
        rd_chk("R8 pol hi", 12'h0D4, hi_w(pol_high));
        rd_chk("R8 en untouched", 12'h0A0, lo_w(m_en));
    endtask

    task automatic t_wo;
        rd_chk("R9 en clr", 12'h0A8, 32'h0);
        rd_chk("R9 sw clr", 12'h0B8, 32'h0);
        rd_chk("R9 edge clr", 12'h0DC, 32'h0);
        rd_chk("R9 unmapped", 12'h0E8, 32'h0);
        rd_chk("R9 unmapped far", 12'h1F0, 32'h0);
    endtask

    task automatic t_ro;
        wr(12'h080, 32'hFFFF_FFFF);
        wr(12'h08C, 32'hFFFF_FFFF);
        wr(12'h090, 32'h0);
        wr(12'h0E0, 32'hFFFF_FFFF);
        rd_chk("R10 en lo", 12'h0A0, lo_w(m_en));
        rd_chk("R10 sel hi", 12'h09C, hi_w(m_sel));
        chk_outs("R10 outs");
    endtask

    task automatic t_sw;
        wr(12'h0B0, 32'hFFFF_FFFF);
        wr(12'h0B4, 32'hFFFF_FFFF);
        wr(12'h0B8, 32'hFFFF_FFFF);
        rd_chk("R11 sw lo", 12'h0B0, 32'h0);
        rd_chk("R11 sw hi", 12'h0B4, 32'h0);
        rd_chk("R11 en kept", 12'h0A4, hi_w(m_en));
        chk_outs("R11 outs");
    endtask

    task automatic t_edge_clr;
        logic [N-1:0] exp;
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h0DC; wdata = 32'hFFFF_FFFF;
        exp = {19'h7_FFFF, 32'h0} & ~lvl_mode;
        #1 chk("R13 hi pulse", {13'b0, edge_clr}, {13'b0, exp});
        addr = 12'h0D8; wdata = 32'h00FF_00FF;
        exp = {19'h0, 32'h00FF_00FF} & ~lvl_mode;
        #1 chk("R13 lo pulse", {13'b0, edge_clr}, {13'b0, exp});
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R13 idle", {13'b0, edge_clr}, 64'd0);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        rd(12'h098, d);
        chk("R14 first", {32'b0, d}, {32'b0, lo_w(m_sel)});
        addr = 12'h0A4;
        repeat (3) @(negedge clk);
        chk("R14 hold", {32'b0, rdata}, {32'b0, lo_w(m_sel)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_enable();
        t_select();
        t_route();
        t_views();
        t_wo();
        t_ro();
        t_sw();
        t_edge_clr();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule